// File: doc/BRIEF.md
# Flash Chip-Erase Command Decoder

This block is the command front end of a small parallel flash model. It watches host bus writes, each of which is a one-cycle `wr_en` pulse carrying an address and a data byte. It recognises the keyed six-write chip-erase sequence. A complete sequence starts an internal erase engine. The engine first writes 00h to every location of a small behavioural array, then waits a programmable settle time, and finally writes FFh to every location.

While the engine runs, host reads return a status byte instead of array data. The host polls bit 7 to learn when the erase has finished. Bits 6 and 2 flip on every status read, so the host can also tell that the erase is still in progress. A failure-injection input makes the erase fail on purpose; the status then shows bit 5, and the failed state is held until the host writes the reset command. While erasing, the block accepts only two commands: the reset command, and a command that pauses the erase. A paused erase can be resumed.

Top module: `flash_cmd_seq`

## Requirements
- R1: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h, given in that order, start an erase. `busy` is high from the clock after the sixth write.
- R2: A coded cycle with a wrong address or wrong data aborts the sequence to read-array mode, and so does a third or sixth write that is not 80h@5555h or 10h@5555h respectively. The array then stays unchanged.
- R3: After reset, `rdata` is 00h, `busy` is low, and location i of the array holds (i*11h) XOR 5Ah. In read-array mode, a read returns the array byte at the low ARR_W address bits one clock after `rd_en`.
- R4: While `busy` is high, reads return the status byte. In that byte, bit 7 is 0, bit 5 is 0, and bits 4, 3, 1 and 0 are 0.
- R5: In every status byte, bit 6 equals bit 2. Both bits invert on each successive status read.
- R6: The erase writes 00h to every location and then FFh to every location. When it completes, `busy` falls, the block returns to read-array mode, and every location reads FFh, so bit 7 reads 1.
- R7: If `fail_inject` is high when the 00h pass ends, the erase stops with the array left at 00h and `busy` low. Reads then return status with bit 7 = 0 and bit 5 = 1, and bits 6 and 2 keep toggling. Only a F0h write leaves this state.
- R8: While `busy` is high, a write whose data is neither F0h nor B0h is ignored, and the erase runs to completion.
- R9: A write of F0h at any address, in any state, returns the block to read-array mode. If an erase is running it is aborted, and `busy` is low on the next clock.
- R10: A write of B0h while `busy` is high pauses the erase. `busy` goes low, reads return array data, and the array is frozen. A later write of 30h resumes the erase where it stopped, with `busy` high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| rd_en | input | 1 | One-cycle bus read strobe |
| addr | input | ADDR_W | Bus address |
| wdata | input | 8 | Write data / command byte |
| fail_inject | input | 1 | Forces the erase to fail at the end of the 00h pass |
| rdata | output | 8 | Registered read data: array byte or status byte |
| busy | output | 1 | High while the erase engine is running |

## Verification
The bound checker watches every cycle for the following:
- each status read after an erase starts shows bit 7 and bit 5 clear, reserved bits zero, and bit 6 equal to bit 2;
- successive status reads alternate bit 6;
- `busy` rises only after a confirm or resume write;
- `busy` falls after any F0h write.

Some behaviours need whole sequences and contents, so only the bench scenarios can show them:
- the aborts at each step of a wrong sequence;
- the final array contents;
- writes being ignored while busy;
- pause and resume;
- the failure path.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W       = 16,
  parameter int ARR_W        = 4,
  parameter int ERASE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              fail_inject,
  output logic [7:0]        rdata,
  output logic              busy
);
  localparam int DEPTH = 1 << ARR_W;
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(16'h5555);
  localparam logic [ADDR_W-1:0] KEY_B = ADDR_W'(16'h2AAA);
  localparam logic [ARR_W-1:0]  LAST  = ARR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  WLAST = CNT_W'(ERASE_CYCLES - 1);

  typedef enum logic [3:0] {
    S_READ, S_C1, S_C2, S_C3, S_C4, S_C5,
    S_ZERO, S_WAIT, S_FILL, S_SUSP, S_FAIL
  } state_t;

  state_t           st, resume_st;
  logic [ARR_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic             tog;
  logic [7:0]       mem [DEPTH];

  wire key1    = wr_en && addr == KEY_A && wdata == 8'hAA;
  wire key2    = wr_en && addr == KEY_B && wdata == 8'h55;
  wire setup   = addr == KEY_A && wdata == 8'h80;
  wire confirm = addr == KEY_A && wdata == 8'h10;
  wire running = st == S_ZERO || st == S_WAIT || st == S_FILL;
  wire stat_md = running || st == S_FAIL;
  wire [7:0] status = {1'b0, tog, st == S_FAIL, 2'b00, tog, 2'b00};

  assign busy = running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_READ;
      resume_st <= S_ZERO;
      idx       <= '0;
      cnt       <= '0;
      tog       <= 1'b0;
      rdata     <= 8'h00;
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= 8'(i * 8'h11) ^ 8'h5A;
    end else begin
      if (rd_en) begin
        rdata <= stat_md ? status : mem[addr[ARR_W-1:0]];
        if (stat_md) tog <= ~tog;
      end
      if (wr_en && wdata == 8'hF0) begin
        st <= S_READ;
      end else if (running && wr_en && wdata == 8'hB0) begin
        resume_st <= st;
        st        <= S_SUSP;
      end else begin
        case (st)
          S_READ: if (key1) st <= S_C1;
          S_C1:   if (wr_en) st <= key2 ? S_C2 : S_READ;
          S_C2:   if (wr_en) st <= setup ? S_C3 : S_READ;
          S_C3:   if (wr_en) st <= key1 ? S_C4 : S_READ;
          S_C4:   if (wr_en) st <= key2 ? S_C5 : S_READ;
          S_C5: if (wr_en) begin
            if (confirm) begin
              st  <= S_ZERO;
              idx <= '0;
              cnt <= '0;
            end else begin
              st <= S_READ;
            end
          end
          S_ZERO: begin
            mem[idx] <= 8'h00;
            idx      <= idx + 1'b1;
            if (idx == LAST) st <= fail_inject ? S_FAIL : S_WAIT;
          end
          S_WAIT: begin
            cnt <= cnt + 1'b1;
            if (cnt == WLAST) st <= S_FILL;
          end
          S_FILL: begin
            mem[idx] <= 8'hFF;
            idx      <= idx + 1'b1;
            if (idx == LAST) st <= S_READ;
          end
          S_SUSP: if (wr_en && wdata == 8'h30) st <= resume_st;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              busy
);
  logic fresh, have, last6;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fresh <= 1'b0;
      have  <= 1'b0;
      last6 <= 1'b0;
    end else begin
      fresh <= rd_en && busy;
      if (fresh) begin
        have  <= 1'b1;
        last6 <= rdata[6];
      end else if (!busy) begin
        have <= 1'b0;
      end
    end
  end

  a_r4_poll_bits: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |-> !rdata[7] && !rdata[5] && rdata[4:3] == 2'b00 && rdata[1:0] == 2'b00);

  a_r5_bit_pair: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |-> rdata[6] == rdata[2]);

  a_r5_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    fresh && have |-> rdata[6] != last6);

  a_r1_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && wdata == 8'h10 && addr == ADDR_W'(16'h5555))
                  || $past(wr_en && wdata == 8'h30));

  a_r9_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wdata == 8'hF0 |=> !busy);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  localparam int ADDR_W = 16;
  localparam int ARR_W  = 4;
  localparam int DEPTH  = 1 << ARR_W;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, fail_inject = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic busy;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(ADDR_W), .ARR_W(ARR_W), .ERASE_CYCLES(40)) i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .fail_inject(fail_inject), .rdata(rdata), .busy(busy));

  // op: 0 = write, 1 = read and compare; {op, req, addr, data, expect}
  localparam int NV = 33;
  localparam logic [37:0] VEC [NV] = '{
    {2'd1, 4'd3, 16'h0003, 8'h00, 8'h69},   // R3 init contents
    {2'd1, 4'd3, 16'h000A, 8'h00, 8'hF0},   // R3
    {2'd1, 4'd3, 16'hFF0F, 8'h00, 8'hA5},   // R3 upper bits ignored
    {2'd0, 4'd2, 16'h5555, 8'hAA, 8'h00},   // R2 wrong second key
    {2'd0, 4'd2, 16'h2AAA, 8'h56, 8'h00},
    {2'd0, 4'd2, 16'h5555, 8'h80, 8'h00},
    {2'd0, 4'd2, 16'h5555, 8'hAA, 8'h00},
    {2'd0, 4'd2, 16'h2AAA, 8'h55, 8'h00},
    {2'd0, 4'd2, 16'h5555, 8'h10, 8'h00},
    {2'd1, 4'd2, 16'h0003, 8'h00, 8'h69},
    {2'd0, 4'd2, 16'h5555, 8'hAA, 8'h00},   // R2 wrong setup command
    {2'd0, 4'd2, 16'h2AAA, 8'h55, 8'h00},
    {2'd0, 4'd2, 16'h5555, 8'hA0, 8'h00},
    {2'd0, 4'd2, 16'h5555, 8'hAA, 8'h00},
    {2'd0, 4'd2, 16'h2AAA, 8'h55, 8'h00},
    {2'd0, 4'd2, 16'h5555, 8'h10, 8'h00},
    {2'd1, 4'd2, 16'h0004, 8'h00, 8'h1E},
    {2'd0, 4'd2, 16'h5555, 8'hAA, 8'h00},   // R2 wrong fourth address
    {2'd0, 4'd2, 16'h2AAA, 8'h55, 8'h00},
    {2'd0, 4'd2, 16'h5555, 8'h80, 8'h00},
    {2'd0, 4'd2, 16'h5554, 8'hAA, 8'h00},
    {2'd0, 4'd2, 16'h2AAA, 8'h55, 8'h00},
    {2'd0, 4'd2, 16'h5555, 8'h10, 8'h00},
    {2'd1, 4'd2, 16'h0000, 8'h00, 8'h5A},
    {2'd0, 4'd2, 16'h5555, 8'hAA, 8'h00},   // R2 wrong confirm
    {2'd0, 4'd2, 16'h2AAA, 8'h55, 8'h00},
    {2'd0, 4'd2, 16'h5555, 8'h80, 8'h00},
    {2'd0, 4'd2, 16'h5555, 8'hAA, 8'h00},
    {2'd0, 4'd2, 16'h2AAA, 8'h55, 8'h00},
    {2'd0, 4'd2, 16'h5555, 8'h30, 8'h00},
    {2'd1, 4'd2, 16'h0001, 8'h00, 8'h4B},
    {2'd0, 4'd2, 16'h5555, 8'h10, 8'h00},   // lone confirm ignored
    {2'd1, 4'd2, 16'h0001, 8'h00, 8'h4B}
  };

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 8'h11) ^ 8'h5A;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic start_erase();
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
    @(negedge clk); addr = 16'h5555; wdata = 8'h10; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_done(string req);
    logic [7:0] d;
    int n = 0;
    d = 8'h00;
    while (busy && n < 2000) begin
      rd(16'h0000, d);
      n++;
    end
    check(!busy, req, busy, 0);
  endtask

  initial begin
    logic [7:0] d, d2;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rdata == 8'h00 && !busy, "R3 reset", rdata, 0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][37:36] == 2'd0) begin
        wr(VEC[v][31:16], VEC[v][15:8]);
      end else begin
        rd(VEC[v][31:16], d);
        check(d == VEC[v][7:0], $sformatf("R%0d vec %0d", VEC[v][35:32], v), d, VEC[v][7:0]);
      end
    end
    check(!busy, "R2 no erase started", busy, 0);

    start_erase();
    check(busy, "R1 busy after confirm", busy, 1);
    rd(16'h0003, d);
    check(d[7] == 1'b0 && d[5] == 1'b0, "R4 status bit7/bit5", d, 0);
    rd(16'h0003, d2);
    check(d2[6] != d[6] && d2[2] == d2[6], "R5 toggle", d2, {1'b0, ~d[6], 3'b0, ~d[6], 2'b0});
    wr(16'h5555, 8'hA0);
    @(negedge clk);
    check(busy, "R8 write ignored while busy", busy, 1);
    wait_done("R6 erase completes");
    for (int i = 0; i < DEPTH; i++) begin
      rd(16'(i), d);
      check(d == 8'hFF, "R6 erased contents", d, 8'hFF);
    end

    do_reset();
    start_erase();
    @(negedge clk);
    wr(16'h1234, 8'hF0);
    check(!busy, "R9 abort clears busy", busy, 0);
    rd(16'h000F, d);
    check(d == init_val(15), "R9 array mode after abort", d, init_val(15));

    do_reset();
    start_erase();
    @(negedge clk);
    wr(16'h0000, 8'hB0);
    check(!busy, "R10 busy low when paused", busy, 0);
    rd(16'h000F, d);
    check(d == init_val(15), "R10 array readable when paused", d, init_val(15));
    repeat (150) @(negedge clk);
    rd(16'h000F, d);
    check(d == init_val(15) && !busy, "R10 frozen while paused", d, init_val(15));
    wr(16'h0000, 8'h30);
    check(busy, "R10 resume", busy, 1);
    wait_done("R10 resumed erase completes");
    rd(16'h000F, d);
    check(d == 8'hFF, "R10 contents after resume", d, 8'hFF);

    do_reset();
    fail_inject = 1'b1;
    start_erase();
    wait_done("R7 busy drops on failure");
    fail_inject = 1'b0;
    rd(16'h0002, d);
    check(d[7] == 1'b0 && d[5] == 1'b1, "R7 fail status", d, 8'h20);
    rd(16'h0002, d2);
    check(d2[6] != d[6] && d2[2] == d2[6] && d2[5], "R7 toggle continues", d2, 8'h20);
    wr(16'h5555, 8'h10);
    rd(16'h0002, d);
    check(d[5] == 1'b1 && !busy, "R7 fail held", d, 8'h20);
    wr(16'h0000, 8'hF0);
    rd(16'h0005, d);
    check(d == 8'h00, "R7 array left at zero", d, 8'h00);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule